// File: doc/BRIEF.md
# Line Alarm Interrupt Controller

This block gathers receive-side alarm levels from a set of line channels and turns them into one interrupt. Each channel has four alarm levels: loss of signal, alarm indication, pattern detection and a line-status alarm. The inputs are synchronised first. Any transition of an alarm, rising or falling, is latched as a change bit in that channel's status word. The interrupt pin is modelled as an open-drain output. It is pulled low while a change bit is pending that its mask lets through and the global enable is set.

Software finds the source in two steps. It reads a summary word that has one bit per channel, and then reads that channel's status word. Reading the status word clears it. Once nothing unmasked is pending, the pin is released. A separate per-channel word shows the present synchronised alarm levels.

Register map (8-bit data, 6-bit address; `addr[5:4]` selects the page and `addr[3:0]` selects the entry):
- `0x00` control. Bit 0 is the global interrupt enable. Read/write.
- `0x01` channel summary. Bit c is set when channel c has an unmasked change pending. Read only, and reading it clears nothing.
- `0x10+c` mask for channel c. Read/write.
- `0x20+c` change status for channel c. Reading it clears it.
- `0x30+c` live alarm levels for channel c. Read only.

Within a channel word the bits are: bit 0 loss of signal, bit 1 alarm indication, bit 2 pattern detection, bit 3 line alarm. The input `alarm_in[c*4+b]` carries bit b of channel c.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: The live register `0x30+c` returns the synchronised levels of channel c's alarm inputs. Bit b of the word is `alarm_in[c*4+b]`.
- R2: A rising or a falling transition of an alarm input sets its change bit. The bit appears in status word `0x20+c` two clock edges after the edge that first samples the new level. This happens whatever the mask setting.
- R3: A read asserts `rd_en` for one cycle, and `rdata` presents the value after that clock edge and holds it until the next read. A read of `0x20+c` returns the change bits and clears them. A second read then returns 0.
- R4: When a new change for a bit arrives on the same edge that a read clears that bit, the bit stays set.
- R5: Bit c of the summary register `0x01` is set when channel c has a change bit that its mask does not block. Reading the summary does not clear it.
- R6: A mask bit of 1 in `0x10+c` keeps the matching alarm out of the summary and away from the interrupt.
- R7: Bit 0 of `0x00` is the global enable. While it is 0, `irq_oe` stays 0 even when unmasked changes are pending.
- R8: `irq_oe` goes to 1 and `irq_n` goes to 0 one edge after an unmasked change bit is pending with the enable set. Both return to the released state one edge after the last such bit has been cleared.
- R9: After reset, `irq_oe` is 0 and `irq_n` is 1. The enable, all masks and all change bits are 0.
- R10: A mask written to `0x10+c` reads back unchanged in its low four bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_in | input | 32 | Asynchronous alarm levels; `alarm_in[c*4+b]` is alarm b of channel c |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, held between reads |
| irq_n | output | 1 | Interrupt level, low while asserted |
| irq_oe | output | 1 | Drive enable of the open-drain pin; 1 pulls low |

## Verification
The alarm inputs are driven with single rising edges, single falling edges, masked transitions, and transitions that arrive while the enable is off. These separate edge detection from level detection, and they separate a gate on the latch from a gate on the interrupt. One change is timed so that it lands on the very edge of a clearing read, which separates "change wins" from "clear wins". The summary is read twice in a row to show that reading it does not clear it. A reference model that follows the behaviour is compared against the outputs on every cycle.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_CH = 8;
    localparam int NUM_AL = 4;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;

    // position of each alarm inside a channel word
    localparam int AL_LOS  = 0;
    localparam int AL_AIS  = 1;
    localparam int AL_PAT  = 2;
    localparam int AL_LINE = 3;

    localparam int IDX_CTRL = 0;
    localparam int IDX_SUM  = 1;

    typedef enum logic [1:0] {
        PG_GLOBAL = 2'd0,
        PG_MASK   = 2'd1,
        PG_STAT   = 2'd2,
        PG_LIVE   = 2'd3
    } page_e;

    typedef struct packed {
        page_e            page;
        logic [IDX_W-1:0] idx;
    } reg_addr_t;

    function automatic reg_addr_t split_addr(input logic [ADDR_W-1:0] a);
        reg_addr_t r;
        r.page = page_e'(a[ADDR_W-1:IDX_W]);
        r.idx  = a[IDX_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/alarm_chg_det.sv
module alarm_chg_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] live,
    output logic [W-1:0] chg
);
    logic [W-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= din;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign live = s2_q;
    assign chg  = s2_q ^ prev_q;
endmodule

// File: rtl/alarm_stat_latch.sv
module alarm_stat_latch #(
    parameter int NCH = 8,
    parameter int NAL = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH*NAL-1:0]       chg,
    input  logic                     clr_en,
    input  logic [$clog2(NCH)-1:0]   clr_ch,
    output logic [NCH*NAL-1:0]       lat
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = clr_en && (int'(clr_ch) == c);

        always_ff @(posedge clk) begin
            if (rst)
                lat[c*NAL +: NAL] <= '0;
            else
                lat[c*NAL +: NAL] <= (hit ? '0 : lat[c*NAL +: NAL]) | chg[c*NAL +: NAL];
        end
    end
endmodule

// File: rtl/alarm_irq_regs.sv
module alarm_irq_regs
    import alarm_irq_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int NAL = NUM_AL
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [NCH*NAL-1:0]     lat,
    input  logic [NCH*NAL-1:0]     live,
    output logic [DATA_W-1:0]      rdata,
    output logic                   gie,
    output logic [NCH*NAL-1:0]     mask,
    output logic                   clr_en,
    output logic [$clog2(NCH)-1:0] clr_ch,
    output logic [NCH-1:0]         summary
);
    reg_addr_t       ra;
    logic            idx_ok;
    logic [NAL-1:0]  sel_mask, sel_lat, sel_live;
    logic [DATA_W-1:0] rd_next;
    logic            unused_wbits;

    assign ra           = split_addr(addr);
    assign idx_ok       = int'(ra.idx) < NCH;
    assign unused_wbits = ^wdata[DATA_W-1:NAL];

    for (genvar c = 0; c < NCH; c++) begin : g_sum
        assign summary[c] = |(lat[c*NAL +: NAL] & ~mask[c*NAL +: NAL]);
    end

    always_comb begin
        sel_mask = '0;
        sel_lat  = '0;
        sel_live = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(ra.idx) == c) begin
                sel_mask = mask[c*NAL +: NAL];
                sel_lat  = lat[c*NAL +: NAL];
                sel_live = live[c*NAL +: NAL];
            end
        end
    end

    always_comb begin
        rd_next = '0;
        case (ra.page)
            PG_GLOBAL: begin
                if (int'(ra.idx) == IDX_CTRL)     rd_next[0] = gie;
                else if (int'(ra.idx) == IDX_SUM) rd_next    = DATA_W'(summary);
            end
            PG_MASK: rd_next = DATA_W'(sel_mask);
            PG_STAT: rd_next = DATA_W'(sel_lat);
            PG_LIVE: rd_next = DATA_W'(sel_live);
            default: rd_next = '0;
        endcase
    end

    assign clr_en = rd_en && (ra.page == PG_STAT) && idx_ok;
    assign clr_ch = ra.idx[$clog2(NCH)-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            gie   <= 1'b0;
            mask  <= '0;
            rdata <= '0;
        end else begin
            if (wr_en) begin
                if (ra.page == PG_GLOBAL && int'(ra.idx) == IDX_CTRL)
                    gie <= wdata[0];
                if (ra.page == PG_MASK) begin
                    for (int c = 0; c < NCH; c++)
                        if (int'(ra.idx) == c)
                            mask[c*NAL +: NAL] <= wdata[NAL-1:0];
                end
            end
            if (rd_en)
                rdata <= rd_next;
        end
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int NUM_CHANNELS = NUM_CH,
    parameter int NUM_ALARMS   = NUM_AL
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_CHANNELS*NUM_ALARMS-1:0] alarm_in,
    input  logic                               rd_en,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W-1:0]                  rdata,
    output logic                               irq_n,
    output logic                               irq_oe
);
    localparam int FLAT = NUM_CHANNELS * NUM_ALARMS;
    localparam int CH_W = $clog2(NUM_CHANNELS);

    logic [FLAT-1:0]         live_w, chg_w, lat_q, mask_w;
    logic                    gie_w, clr_en_w;
    logic [CH_W-1:0]         clr_ch_w;
    logic [NUM_CHANNELS-1:0] summary_w;
    logic                    irq_q;

    alarm_chg_det #(.W(FLAT)) u_det (
        .clk  (clk),
        .rst  (rst),
        .din  (alarm_in),
        .live (live_w),
        .chg  (chg_w)
    );

    alarm_stat_latch #(.NCH(NUM_CHANNELS), .NAL(NUM_ALARMS)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .chg    (chg_w),
        .clr_en (clr_en_w),
        .clr_ch (clr_ch_w),
        .lat    (lat_q)
    );

    alarm_irq_regs #(.NCH(NUM_CHANNELS), .NAL(NUM_ALARMS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .lat     (lat_q),
        .live    (live_w),
        .rdata   (rdata),
        .gie     (gie_w),
        .mask    (mask_w),
        .clr_en  (clr_en_w),
        .clr_ch  (clr_ch_w),
        .summary (summary_w)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= gie_w && (|summary_w);
    end

    assign irq_oe = irq_q;
    assign irq_n  = ~irq_q;
endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk #(
    parameter int NCH = 8,
    parameter int NAL = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH*NAL-1:0]     chg,
    input logic [NCH*NAL-1:0]     lat,
    input logic [NCH*NAL-1:0]     mask,
    input logic                   gie,
    input logic                   clr_en,
    input logic [$clog2(NCH)-1:0] clr_ch,
    input logic                   irq_oe
);
    assert_chg_latches_R2: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |=> ((lat & $past(chg)) == $past(chg)));

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (gie && ((lat & ~mask) != '0)) |=> irq_oe);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !gie |=> !irq_oe);

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        ((lat & ~mask) == '0) |=> !irq_oe);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
            (clr_en && int'(clr_ch) == c && chg[c*NAL +: NAL] == '0)
            |=> (lat[c*NAL +: NAL] == '0));

        assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
            !(clr_en && int'(clr_ch) == c)
            |=> ((lat[c*NAL +: NAL] & $past(lat[c*NAL +: NAL])) == $past(lat[c*NAL +: NAL])));
    end
endmodule

bind alarm_irq_ctrl alarm_irq_chk #(.NCH(NUM_CHANNELS), .NAL(NUM_ALARMS)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .chg    (chg_w),
    .lat    (lat_q),
    .mask   (mask_w),
    .gie    (gie_w),
    .clr_en (clr_en_w),
    .clr_ch (clr_ch_w),
    .irq_oe (irq_oe)
);

// File: tb/sim_alarm_irq_ctrl.sv
module sim_alarm_irq_ctrl;
    localparam int NCH  = 8;
    localparam int NAL  = 4;
    localparam int FLAT = NCH * NAL;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [FLAT-1:0] alarm = '0;
    logic            rd_en = 1'b0, wr_en = 1'b0;
    logic [5:0]      addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            irq_n, irq_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    alarm_irq_ctrl u0 (
        .clk(clk), .rst(rst), .alarm_in(alarm), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [FLAT-1:0] hist[$];     // oldest first: previous, current, newest sample
    logic [FLAT-1:0] m_lat;
    logic [NAL-1:0]  m_mask[NCH];
    bit              m_gie, m_irq;
    logic [7:0]      m_rd;

    function automatic logic [7:0] model_read(input logic [5:0] a);
        int pg  = int'(a[5:4]);
        int idx = int'(a[3:0]);
        logic [7:0] v = '0;
        if (pg == 0) begin
            if (idx == 0) v = {7'd0, m_gie};
            else if (idx == 1)
                for (int c = 0; c < NCH; c++)
                    v[c] = |(m_lat[c*NAL +: NAL] & ~m_mask[c]);
        end else if (idx < NCH) begin
            if (pg == 1) v = {4'd0, m_mask[idx]};
            if (pg == 2) v = {4'd0, m_lat[idx*NAL +: NAL]};
            if (pg == 3) v = {4'd0, hist[1][idx*NAL +: NAL]};
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist = '{'0, '0, '0};
            m_lat = '0;
            foreach (m_mask[c]) m_mask[c] = '0;
            m_gie = 0; m_irq = 0; m_rd = '0;
        end else begin
            logic [FLAT-1:0] changes, clr;
            bit pend;
            changes = hist[1] ^ hist[0];
            pend = 0;
            for (int c = 0; c < NCH; c++)
                if ((m_lat[c*NAL +: NAL] & ~m_mask[c]) != 0) pend = 1;
            clr = '0;
            if (rd_en) begin
                m_rd = model_read(addr);
                if (addr[5:4] == 2'd2 && int'(addr[3:0]) < NCH)
                    clr[int'(addr[3:0])*NAL +: NAL] = '1;
            end
            if (wr_en) begin
                if (addr == 6'h00) m_gie = wdata[0];
                if (addr[5:4] == 2'd1 && int'(addr[3:0]) < NCH)
                    m_mask[int'(addr[3:0])] = wdata[3:0];
            end
            m_irq = m_gie_prev_and(pend);
            m_lat = (m_lat & ~clr) | changes;
            void'(hist.pop_front());
            hist.push_back(alarm);
        end
    end

    bit gie_before;
    function automatic bit m_gie_prev_and(input bit p);
        return gie_before && p;
    endfunction
    always @(negedge clk) gie_before = m_gie;

    always @(negedge clk) begin
        if (!rst) begin
            check(irq_oe == m_irq, "R8 model irq_oe", int'(irq_oe), int'(m_irq));
            check(irq_n == !m_irq, "R8 model irq_n", int'(irq_n), int'(!m_irq));
            check(rdata == m_rd, "R3 model rdata", int'(rdata), int'(m_rd));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- register access tasks (start and end at a falling edge) ----------------
    task automatic reg_rd(input logic [5:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        check(irq_oe == 1'b0 && irq_n == 1'b1, "R9 pin released", int'(irq_oe), 0);
        reg_rd(6'h00, v); check(v == 8'h00, "R9 enable clear", v, 8'h00);
        reg_rd(6'h10, v); check(v == 8'h00, "R9 mask clear", v, 8'h00);
        reg_rd(6'h23, v); check(v == 8'h00, "R9 status clear", v, 8'h00);

        // R7 enable write/readback
        reg_wr(6'h00, 8'h01);
        reg_rd(6'h00, v); check(v == 8'h01, "R7 enable readback", v, 8'h01);

        // rising edge on channel 2 alarm indication (bit 1)
        alarm[2*NAL + 1] = 1'b1;
        idle(4);
        check(irq_oe == 1'b1 && irq_n == 1'b0, "R8 irq asserted", int'(irq_oe), 1);
        reg_rd(6'h32, v); check(v == 8'h02, "R1 live level ch2", v, 8'h02);
        reg_rd(6'h01, v); check(v == 8'h04, "R5 summary ch2", v, 8'h04);
        reg_rd(6'h01, v); check(v == 8'h04, "R5 summary not cleared", v, 8'h04);
        reg_rd(6'h22, v); check(v == 8'h02, "R2 rising latched", v, 8'h02);
        reg_rd(6'h22, v); check(v == 8'h00, "R3 cleared by read", v, 8'h00);
        check(irq_oe == 1'b0 && irq_n == 1'b1, "R8 irq released", int'(irq_oe), 0);

        // falling edge
        alarm[2*NAL + 1] = 1'b0;
        idle(4);
        reg_rd(6'h22, v); check(v == 8'h02, "R2 falling latched", v, 8'h02);
        idle(1);

        // masking on channel 5, loss of signal (bit 0)
        reg_wr(6'h15, 8'h01);
        reg_rd(6'h15, v); check(v == 8'h01, "R10 mask readback", v, 8'h01);
        alarm[5*NAL + 0] = 1'b1;
        idle(4);
        check(irq_oe == 1'b0, "R6 masked no irq", int'(irq_oe), 0);
        reg_rd(6'h01, v); check(v == 8'h00, "R6 masked not in summary", v, 8'h00);
        reg_rd(6'h25, v); check(v == 8'h01, "R2 masked still latched", v, 8'h01);

        // global enable off
        reg_wr(6'h00, 8'h00);
        alarm[0*NAL + 3] = 1'b1;
        idle(4);
        check(irq_oe == 1'b0, "R7 disabled no irq", int'(irq_oe), 0);
        reg_rd(6'h01, v); check(v == 8'h01, "R5 summary ch0", v, 8'h01);
        reg_wr(6'h00, 8'h01);
        idle(1);
        check(irq_oe == 1'b1, "R7 enable raises irq", int'(irq_oe), 1);
        reg_rd(6'h20, v); check(v == 8'h08, "R3 ch0 line alarm", v, 8'h08);
        idle(1);
        check(irq_oe == 1'b0, "R8 released after clear", int'(irq_oe), 0);

        // change coinciding with a clearing read on channel 1, pattern alarm (bit 2)
        alarm[1*NAL + 2] = 1'b1;
        idle(4);
        alarm[1*NAL + 2] = 1'b0;
        idle(2);
        reg_rd(6'h21, v); check(v == 8'h04, "R4 first read", v, 8'h04);
        reg_rd(6'h21, v); check(v == 8'h04, "R4 new change kept", v, 8'h04);
        reg_rd(6'h21, v); check(v == 8'h00, "R3 finally cleared", v, 8'h00);
        idle(2);
        check(irq_oe == 1'b0 && irq_n == 1'b1, "R8 idle released", int'(irq_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule